// File: doc/BRIEF.md
# Two-Cycle AES-128 Encryption Round

This block performs one AES-128 encryption round as a pipeline stage with a register inside the round. A 128-bit state and a valid flag enter on one clock edge. The first half of the round applies byte substitution to all sixteen bytes in parallel, then the row rotation, and registers the result. The second half applies the column mix and the round-key XOR, then registers the result again. The register in the middle keeps the S-box network and the column-mixing XOR tree in separate clock cycles.

Several of these stages are chained to build an unrolled cipher. The key for a block must be presented one cycle after its state, because that is when the state reaches the key XOR. A parameter builds the variant used for the last round of the cipher, which leaves out the column mix. The stage accepts a new block on every clock and has no stall input.

Top module: `aes_round_stage`

## Requirements
- R1: A synchronous active-low reset clears both internal valid flags. `out_valid` is 0 after any clock edge at which `rst_n` is low, whatever `in_valid` is.
- R2: A block accepted with `in_valid` high on clock edge n appears with `out_valid` high after edge n+2. Blocks may enter on consecutive edges, and each one produces its own result in the same order.
- R3: Every state byte is replaced by the AES S-box value of that byte, for all 16 bytes in parallel. For example, a final-round stage with a zero key and every input byte 0x19 outputs every byte as 0xD4.
- R4: Byte k of a state sits at bits [127-8k -: 8], in row k%4 and column k/4. After substitution, row r is rotated left by r byte positions, so output position (r,c) takes the byte from input position (r,(c+r)%4).
- R5: When FINAL_ROUND=0, each 4-byte column (a0..a3) becomes b_r = 2·a_r ^ 3·a_(r+1) ^ a_(r+2) ^ a_(r+3), indices taken mod 4, in GF(2^8). Multiplication by 2 is a left shift, XORed with 0x1B when the shifted-out bit was 1. Multiplication by 3 is 2·x ^ x.
- R6: The last operation is a bitwise XOR with `round_key`, sampled on the edge one cycle after the state was accepted (edge n+1).
- R7: When FINAL_ROUND=1, the column mix is skipped and the output is the shifted, substituted state XORed with the key.
- R8: `out_state` keeps its previous value across any edge at which no result completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_state` holds a block this cycle |
| in_state | input | 128 | Round input state, byte 0 in the MSBs |
| round_key | input | 128 | Round key, presented one cycle after its state |
| out_valid | output | 1 | `out_state` holds a finished round |
| out_state | output | 128 | Round output state |

## Verification
The bench targets the one-cycle key skew. A design that used the key present at state entry would corrupt every block in a back-to-back stream in which each block carries its own key. Published first-round and last-round vectors cover two errors: a row rotation in the wrong direction, which still gives plausible bytes, and a missing 0x1B reduction, which fails only on bytes with the top bit set. Streams with gaps, and `in_valid` held high during reset, expose a valid flag that escapes reset or an output register that reloads on idle cycles.

// File: rtl/aes_round_stage.sv
module aes_round_stage #(
  parameter bit FINAL_ROUND = 1'b0,
  parameter int BYTES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [BYTES*8-1:0]   in_state,
  input  logic [BYTES*8-1:0]   round_key,
  output logic                 out_valid,
  output logic [BYTES*8-1:0]   out_state
);
  localparam int W = BYTES * 8;
  localparam int ROWS = 4;
  localparam int COLS = BYTES / ROWS;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] r, s;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gmul(r, r);
      if (i != 0) r = gmul(r, a);
    end
    s = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
    return s;
  endfunction

  logic [W-1:0] sub_shift, mixed, s1_state;
  logic         s1_valid;

  for (genvar k = 0; k < BYTES; k++) begin : g_sub
    localparam int R = k % ROWS;
    localparam int C = k / ROWS;
    localparam int SRC = R + ROWS * ((C + R) % COLS);
    assign sub_shift[W-1-8*k -: 8] = sbox(in_state[W-1-8*SRC -: 8]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
    if (in_valid) s1_state <= sub_shift;
  end

  if (FINAL_ROUND) begin : g_last
    assign mixed = s1_state;
  end else begin : g_mix
    for (genvar c = 0; c < COLS; c++) begin : g_col
      for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int B0 = ROWS * c + r;
        localparam int B1 = ROWS * c + (r + 1) % ROWS;
        localparam int B2 = ROWS * c + (r + 2) % ROWS;
        localparam int B3 = ROWS * c + (r + 3) % ROWS;
        assign mixed[W-1-8*B0 -: 8] = xt(s1_state[W-1-8*B0 -: 8])
                                    ^ xt(s1_state[W-1-8*B1 -: 8]) ^ s1_state[W-1-8*B1 -: 8]
                                    ^ s1_state[W-1-8*B2 -: 8] ^ s1_state[W-1-8*B3 -: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
    if (s1_valid) out_state <= mixed ^ round_key;
  end
endmodule

module aes_round_stage_chk #(
  parameter bit FINAL_ROUND = 1'b0,
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         s1_valid,
  input logic [W-1:0] s1_state,
  input logic [W-1:0] round_key,
  input logic         out_valid,
  input logic [W-1:0] out_state
);
  assert_rst_clears_R1: assert property (@(posedge clk) !rst_n |=> !s1_valid && !out_valid);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> s1_valid);
  assert_no_accept_R2: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !s1_valid);
  assert_finish_R2: assert property (@(posedge clk) disable iff (!rst_n) s1_valid |=> out_valid);
  assert_no_finish_R2: assert property (@(posedge clk) disable iff (!rst_n) !s1_valid |=> !out_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n) !s1_valid |=> $stable(out_state));
  if (FINAL_ROUND) begin : g_fin
    assert_final_xor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_state == ($past(s1_state) ^ $past(round_key)));
  end
endmodule

bind aes_round_stage aes_round_stage_chk #(.FINAL_ROUND(FINAL_ROUND), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .s1_valid(s1_valid), .s1_state(s1_state),
  .round_key(round_key), .out_valid(out_valid), .out_state(out_state)
);

// File: tb/tb_aes_round_stage.sv
module tb_aes_round_stage;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [127:0] in_state = '0;
  logic [127:0] round_key = '0;
  logic ov0, ov1;
  logic [127:0] os0, os1;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] sb [256];
  logic [127:0] pend_key = '0;

  // models: index 0 = full round, 1 = final round
  logic m1_v = 1'b0, m2_v [2] = '{1'b0, 1'b0};
  logic [127:0] m1_s = '0, m2_s [2];
  bit m2_known [2] = '{1'b0, 1'b0};

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_round_stage #(.FINAL_ROUND(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
    .round_key(round_key), .out_valid(ov0), .out_state(os0));

  aes_round_stage #(.FINAL_ROUND(1'b1)) dut_final (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
    .round_key(round_key), .out_valid(ov1), .out_state(os1));

  function automatic logic [7:0] m2(input logic [7:0] a);
    logic [8:0] t = {a, 1'b0};
    if (t[8]) t = t ^ 9'h11b;
    return t[7:0];
  endfunction

  function automatic logic [127:0] ref_round(input logic [127:0] st, input logic [127:0] k, input bit fin);
    logic [7:0] a [4][4];
    logic [7:0] b [4][4];
    logic [127:0] res;
    for (int i = 0; i < 16; i++) a[i%4][i/4] = sb[st[127-8*i -: 8]];
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) b[r][c] = a[r][(c+r)%4];
    if (!fin)
      for (int c = 0; c < 4; c++) begin
        for (int r = 0; r < 4; r++)
          a[r][c] = m2(b[r][c]) ^ m2(b[(r+1)%4][c]) ^ b[(r+1)%4][c] ^ b[(r+2)%4][c] ^ b[(r+3)%4][c];
      end
    else a = b;
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = a[i%4][i/4];
    return res ^ k;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    for (int d = 0; d < 2; d++) begin
      if (m1_v) begin
        m2_s[d] = ref_round(m1_s, round_key, d == 1);
        m2_known[d] = 1'b1;
      end
      m2_v[d] = rst_n ? m1_v : 1'b0;
    end
    if (in_valid) m1_s = in_state;
    m1_v = rst_n ? in_valid : 1'b0;
    // R2 latency and R1 reset on valid; R3..R8 on data
    check(ov0 === m2_v[0], "R2 valid (full)", {127'b0, ov0}, {127'b0, m2_v[0]});
    check(ov1 === m2_v[1], "R2 valid (final)", {127'b0, ov1}, {127'b0, m2_v[1]});
    if (m2_known[0]) check(os0 === m2_s[0], "R5/R6/R8 state (full)", os0, m2_s[0]);
    if (m2_known[1]) check(os1 === m2_s[1], "R7/R8 state (final)", os1, m2_s[1]);
  endtask

  task automatic cyc(input logic v, input logic [127:0] st, input logic [127:0] k);
    round_key = pend_key;
    in_valid = v;
    in_state = st;
    pend_key = k;
    tick();
  endtask

  initial begin
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]} ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  end

  initial begin
    #1;
    // R1: reset with in_valid asserted
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) cyc(1'b1, 128'h1, 128'h0);
    check(ov0 === 1'b0 && ov1 === 1'b0, "R1 reset clears", {126'b0, ov0, ov1}, 128'h0);
    rst_n = 1'b1;
    cyc(1'b0, '0, '0);
    cyc(1'b0, '0, '0);

    // R3: 0x19 -> 0xD4 on final variant with zero key
    cyc(1'b1, {16{8'h19}}, 128'h0);
    cyc(1'b0, '0, '0);
    check(ov1 === 1'b1 && os1 === {16{8'hd4}}, "R3 sbox 19->d4", os1, {16{8'hd4}});

    // R4/R5/R6: known first-round vector
    cyc(1'b1, 128'h193de3bea0f4e22b9ac68d2ae9f84808, 128'ha0fafe1788542cb123a339392a6c7605);
    cyc(1'b0, '0, '0);
    check(os0 === 128'ha49c7ff2689f352b6b5bea43026a5049, "R4/R5 full round vector", os0,
          128'ha49c7ff2689f352b6b5bea43026a5049);

    // R7: known last-round vector
    cyc(1'b1, 128'heb40f21e592e38848ba113e71bc342d2, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    cyc(1'b0, '0, '0);
    check(os1 === 128'h3925841d02dc09fbdc118597196a0b32, "R7 final round vector", os1,
          128'h3925841d02dc09fbdc118597196a0b32);

    // R8: idle cycles with changing inputs leave output alone
    for (int i = 0; i < 3; i++) cyc(1'b0, {4{$urandom}}, {4{$urandom}});
    check(os1 === 128'h3925841d02dc09fbdc118597196a0b32, "R8 hold when idle", os1,
          128'h3925841d02dc09fbdc118597196a0b32);

    // corner patterns: all zeros, all ones
    cyc(1'b1, '0, '0);
    cyc(1'b1, '1, '1);
    cyc(1'b0, '0, '0);

    // R2/R6: back-to-back stream with per-block keys and gaps
    for (int i = 0; i < 200; i++)
      cyc(($urandom % 4) != 0, {$urandom, $urandom, $urandom, $urandom},
          {$urandom, $urandom, $urandom, $urandom});
    cyc(1'b0, '0, '0);
    cyc(1'b0, '0, '0);

    // R1: reset mid-stream drops in-flight blocks
    cyc(1'b1, 128'h5, 128'h6);
    rst_n = 1'b0;
    cyc(1'b1, 128'h7, 128'h8);
    rst_n = 1'b1;
    cyc(1'b0, '0, '0);
    check(ov0 === 1'b0 && ov1 === 1'b0, "R1 reset drops in-flight", {126'b0, ov0, ov1}, 128'h0);
    cyc(1'b0, '0, '0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule